// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between two independent ports (left and right) of a shared word memory. Each port presents an enable, a write strobe and a 14-bit word address every clock. When both ports are enabled on the same address in the same cycle, the block picks the port that keeps the location and pulls the other port's active-low busy flag down in that same cycle. A busy port's write is dropped, while its read still returns data.

A strap input selects master or slave operation. As master, the block runs its own arbitration and drives the busy flags. As slave, no local arbitration takes place. Each busy flag comes from a per-port external busy input, normally wired from a master device that serves the other half of a wider data word, and that input gates the port's write. A small behavioural memory with gated writes is included so that the effect of arbitration can be seen at the read ports.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: With no collision (either port disabled, or the two addresses different), both busy outputs are high (1), including during and right after reset.
- R2: In master mode a busy output goes low only when both enables are 1 and all 14 address bits are equal in the same cycle. Addresses differing only in bit 13, or only above the memory index bits, raise no busy.
- R3: In master mode at most one busy output is low. When both ports arrive at the shared address in the same cycle, neither having been there the cycle before, the left port wins and `r_busy_n` goes low.
- R4: A port that was enabled on an address in the previous cycle and stays there keeps it. The other port, arriving at that address later, gets its busy low, on either side.
- R5: While a collision continues with both ports staying put, the same winner is kept every cycle until the winner drops its enable or moves.
- R6: A write from a port whose busy output is low does not change the memory. The winner's write does land, and a busy port's read still returns the stored word.
- R7: Both ports reading the same address in the same cycle both receive the stored word.
- R8: In slave mode (`master_sel`=0) each busy output equals that port's external busy input, whatever the addresses.
- R9: In slave mode a port whose external busy input is low has its write suppressed, and the other port's write still lands.
- R10: Read data appears on the clock edge that samples the read. The memory is indexed by the low MEM_AW address bits (default 8), so addresses equal in those bits alias to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1: local arbitration drives busy; 0: busy taken from the external inputs |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe (1 = write) |
| l_addr | input | 14 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, registered |
| l_busy_n | output | 1 | Left port busy, active low |
| l_busy_in_n | input | 1 | Left external busy in slave mode, active low |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | 14 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, registered |
| r_busy_n | output | 1 | Right port busy, active low |
| r_busy_in_n | input | 1 | Right external busy in slave mode, active low |

## Verification
The only state is the previous-cycle enable and address of each port and one bit recording that the right port won the last collision. If any of it is wrong, the error shows on a busy output in the very cycle of the next collision, with the wrong winner or a busy flag on a fresh or repeated collision. It shows no earlier. A wrong write gate shows as a changed word on the next read of that address, one edge after the read is issued.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int NPORT = 2;
  localparam int PL = 0;
  localparam int PR = 1;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Winner of a collision from tenure: a port already sitting on the
  // address keeps it; if both were, the previous winner keeps it; a fresh
  // tie goes to the left side.
  function automatic side_e pick_winner(input logic l_stay, input logic r_stay,
                                        input logic right_held);
    if (r_stay && (!l_stay || right_held)) return SIDE_R;
    return SIDE_L;
  endfunction

  // A write lands only when the port is enabled, writing and not blocked.
  function automatic logic write_lands(input logic en, input logic we, input logic blocked);
    return en && we && !blocked;
  endfunction
endpackage

// File: rtl/dpa_port_tracker.sv
module dpa_port_tracker #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          stayed
);
  logic          prev_en;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  // Port held this address in the previous cycle and still does.
  assign stayed = en && prev_en && (prev_addr == addr);

  AST_STAY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(addr)) |-> stayed); // R4
endmodule

// File: rtl/dpa_collision_arb.sv
module dpa_collision_arb
  import dpa_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          en_l,
  input  logic          en_r,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  input  logic          stay_l,
  input  logic          stay_r,
  input  logic          ext_busy_l_n,
  input  logic          ext_busy_r_n,
  output logic          busy_l_n,
  output logic          busy_r_n,
  output logic          hit
);
  logic  right_held_q;
  side_e winner;
  logic  lose_l, lose_r;

  assign hit    = en_l && en_r && (addr_l == addr_r);
  assign winner = pick_winner(stay_l, stay_r, right_held_q);
  assign lose_l = master && hit && (winner == SIDE_R);
  assign lose_r = master && hit && (winner == SIDE_L);

  assign busy_l_n = master ? !lose_l : ext_busy_l_n;
  assign busy_r_n = master ? !lose_r : ext_busy_r_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) right_held_q <= 1'b0;
    else        right_held_q <= lose_l;
  end

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (master && (!busy_l_n || !busy_r_n)) |-> (en_l && en_r && addr_l == addr_r)); // R2
  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> (busy_l_n || busy_r_n)); // R3
  AST_FRESH_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (master && hit && !stay_l && !stay_r) |-> (busy_l_n && !busy_r_n)); // R3
  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (master && hit && stay_r && !stay_l) |-> !busy_l_n); // R4
  AST_WINNER_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (master && hit && stay_l && stay_r && $past(master && !busy_l_n)) |-> !busy_l_n); // R5
  AST_SLAVE_NO_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && ext_busy_l_n && ext_busy_r_n) |-> (busy_l_n && busy_r_n)); // R8
endmodule

// File: rtl/dpa_mem.sv
module dpa_mem
  import dpa_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MEM_AW = 8
) (
  input  logic                         clk,
  input  logic [NPORT-1:0]             en,
  input  logic [NPORT-1:0]             we,
  input  logic [NPORT-1:0]             blk,
  input  logic [NPORT-1:0][MEM_AW-1:0] idx,
  input  logic [NPORT-1:0][DW-1:0]     wdata,
  output logic [NPORT-1:0][DW-1:0]     rdata,
  output logic [NPORT-1:0]             wr_fire
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] store [DEPTH];

  for (genvar p = 0; p < NPORT; p++) begin : g_fire
    assign wr_fire[p] = write_lands(en[p], we[p], blk[p]);
  end

  // Higher index written first so the left port (index 0) lands last.
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wr_fire[p]) store[idx[p]] <= wdata[p];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (en[p]) rdata[p] <= store[idx[p]];
    end
  end
endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
  import dpa_pkg::*;
#(
  parameter int AW     = 14,
  parameter int DW     = 8,
  parameter int MEM_AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy_n,
  input  logic          l_busy_in_n,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy_n,
  input  logic          r_busy_in_n
);
  logic [NPORT-1:0]             en_v, we_v, stay_v, blk_v, fire_v;
  logic [NPORT-1:0][AW-1:0]     addr_v;
  logic [NPORT-1:0][MEM_AW-1:0] idx_v;
  logic [NPORT-1:0][DW-1:0]     wdata_v, rdata_v;
  logic                         same_word_hit;

  assign en_v    = {r_en, l_en};
  assign we_v    = {r_we, l_we};
  assign addr_v  = {r_addr, l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_tracker #(.AW(AW)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_v[p]),
      .addr   (addr_v[p]),
      .stayed (stay_v[p])
    );
    assign idx_v[p] = addr_v[p][MEM_AW-1:0];
  end

  dpa_collision_arb #(.AW(AW)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .master       (master_sel),
    .en_l         (l_en),
    .en_r         (r_en),
    .addr_l       (l_addr),
    .addr_r       (r_addr),
    .stay_l       (stay_v[PL]),
    .stay_r       (stay_v[PR]),
    .ext_busy_l_n (l_busy_in_n),
    .ext_busy_r_n (r_busy_in_n),
    .busy_l_n     (l_busy_n),
    .busy_r_n     (r_busy_n),
    .hit          (same_word_hit)
  );

  assign blk_v = {!r_busy_n, !l_busy_n};

  dpa_mem #(.DW(DW), .MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .en      (en_v),
    .we      (we_v),
    .blk     (blk_v),
    .idx     (idx_v),
    .wdata   (wdata_v),
    .rdata   (rdata_v),
    .wr_fire (fire_v)
  );

  assign l_rdata = rdata_v[PL];
  assign r_rdata = rdata_v[PR];

  AST_NO_WRITE_LEFT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> !fire_v[PL]); // R6 R9
  AST_NO_WRITE_RIGHT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> !fire_v[PR]); // R6 R9
  AST_QUIET_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !same_word_hit) |-> (l_busy_n && r_busy_n)); // R1
endmodule

// File: tb/tb_dpa_collision_arbiter.sv
module tb_dpa_collision_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        master_sel;
  logic        l_en, l_we, r_en, r_we;
  logic [13:0] l_addr, r_addr;
  logic [7:0]  l_wdata, r_wdata, l_rdata, r_rdata;
  logic        l_busy_n, r_busy_n, l_busy_in_n, r_busy_in_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  dpa_collision_arbiter dut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_n(l_busy_n), .l_busy_in_n(l_busy_in_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_n(r_busy_n), .r_busy_in_n(r_busy_in_n)
  );

  // {l_en, l_addr, r_en, r_addr, expected l_busy_n, expected r_busy_n}
  localparam int NV = 16;
  localparam logic [31:0] VT [NV] = '{
    {1'b0, 14'h0000, 1'b0, 14'h0000, 1'b1, 1'b1}, // R1 idle
    {1'b1, 14'h0010, 1'b1, 14'h0020, 1'b1, 1'b1}, // R2 different words
    {1'b1, 14'h2010, 1'b1, 14'h0010, 1'b1, 1'b1}, // R2 differ in bit 13
    {1'b0, 14'h0000, 1'b0, 14'h0000, 1'b1, 1'b1}, // R1
    {1'b1, 14'h0100, 1'b1, 14'h0100, 1'b1, 1'b0}, // R3 fresh tie
    {1'b1, 14'h0100, 1'b1, 14'h0100, 1'b1, 1'b0}, // R5 left keeps
    {1'b0, 14'h0000, 1'b1, 14'h0100, 1'b1, 1'b1}, // R1 left leaves
    {1'b1, 14'h0100, 1'b1, 14'h0100, 1'b0, 1'b1}, // R4 right holder
    {1'b1, 14'h0100, 1'b1, 14'h0100, 1'b0, 1'b1}, // R5 right keeps
    {1'b1, 14'h0100, 1'b0, 14'h0000, 1'b1, 1'b1}, // R1 right leaves
    {1'b0, 14'h0000, 1'b0, 14'h0000, 1'b1, 1'b1}, // R1
    {1'b1, 14'h3FFF, 1'b0, 14'h0000, 1'b1, 1'b1}, // R1 left alone
    {1'b1, 14'h3FFF, 1'b1, 14'h3FFF, 1'b1, 1'b0}, // R4 left holder
    {1'b1, 14'h3FFE, 1'b1, 14'h3FFF, 1'b1, 1'b1}, // R2 left moved away
    {1'b1, 14'h3FFF, 1'b1, 14'h3FFF, 1'b0, 1'b1}, // R4 left returns late
    {1'b0, 14'h0000, 1'b0, 14'h0000, 1'b1, 1'b1}  // R1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive after the falling edge; busy is combinational and read 5 ns later.
  task automatic drive(input logic le, input logic lwe, input logic [13:0] la, input logic [7:0] lwd,
                       input logic re, input logic rwe, input logic [13:0] ra, input logic [7:0] rwd);
    @(negedge clk);
    l_en = le; l_we = lwe; l_addr = la; l_wdata = lwd;
    r_en = re; r_we = rwe; r_addr = ra; r_wdata = rwd;
    #5;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 14'h0, 8'h0, 1'b0, 1'b0, 14'h0, 8'h0);
  endtask

  // Read data is registered on the next rising edge.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(20 * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_sel = 1'b1;
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    l_en = 0; l_we = 0; l_addr = '0; l_wdata = '0;
    r_en = 0; r_we = 0; r_addr = '0; r_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset l_busy_n", {7'b0, l_busy_n}, 8'd1);
    chk("R1 reset r_busy_n", {7'b0, r_busy_n}, 8'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VT[i][31], 1'b0, VT[i][30:17], 8'h0, VT[i][16], 1'b0, VT[i][15:2], 8'h0);
      chk($sformatf("R1-R5 table %0d l_busy_n", i), {7'b0, l_busy_n}, {7'b0, VT[i][1]});
      chk($sformatf("R1-R5 table %0d r_busy_n", i), {7'b0, r_busy_n}, {7'b0, VT[i][0]});
    end

    // R6: both write different words, then a fresh tie writes the same word
    drive(1'b1, 1'b1, 14'h040, 8'h11, 1'b1, 1'b1, 14'h050, 8'h5A);
    idle();
    drive(1'b1, 1'b1, 14'h040, 8'h22, 1'b1, 1'b1, 14'h040, 8'h33);
    chk("R6 tie write r_busy_n", {7'b0, r_busy_n}, 8'd0);
    idle();
    drive(1'b0, 1'b0, 14'h0, 8'h0, 1'b1, 1'b0, 14'h040, 8'h0);
    tick();
    chk("R6 winner write landed", r_rdata, 8'h22);

    // R4/R6: right holds 0x050, left write arrives late and is dropped
    drive(1'b0, 1'b0, 14'h0, 8'h0, 1'b1, 1'b0, 14'h050, 8'h0);
    drive(1'b1, 1'b1, 14'h050, 8'h77, 1'b1, 1'b0, 14'h050, 8'h0);
    chk("R4 late left busy", {7'b0, l_busy_n}, 8'd0);
    tick();
    chk("R6 holder read", r_rdata, 8'h5A);
    idle();
    drive(1'b1, 1'b0, 14'h050, 8'h0, 1'b0, 1'b0, 14'h0, 8'h0);
    tick();
    chk("R6 busy write suppressed", l_rdata, 8'h5A);

    // R7: simultaneous reads of one word
    idle();
    drive(1'b1, 1'b0, 14'h040, 8'h0, 1'b1, 1'b0, 14'h040, 8'h0);
    tick();
    chk("R7 left read", l_rdata, 8'h22);
    chk("R7 right read while busy", r_rdata, 8'h22);

    // R10/R2: alias of low index bits, no busy since full addresses differ
    idle();
    drive(1'b1, 1'b0, 14'h140, 8'h0, 1'b1, 1'b0, 14'h040, 8'h0);
    chk("R2 alias no busy l", {7'b0, l_busy_n}, 8'd1);
    chk("R2 alias no busy r", {7'b0, r_busy_n}, 8'd1);
    tick();
    chk("R10 aliased read", l_rdata, 8'h22);

    // Slave mode
    idle();
    master_sel = 1'b0;
    drive(1'b1, 1'b1, 14'h061, 8'h0F, 1'b1, 1'b1, 14'h062, 8'hF0);
    chk("R8 slave l_busy_n high", {7'b0, l_busy_n}, 8'd1);
    tick();
    drive(1'b0, 1'b0, 14'h0, 8'h0, 1'b0, 1'b0, 14'h0, 8'h0);
    l_busy_in_n = 1'b0;
    drive(1'b1, 1'b1, 14'h061, 8'hAA, 1'b1, 1'b1, 14'h062, 8'hBB);
    chk("R8 slave l_busy_n follows input", {7'b0, l_busy_n}, 8'd0);
    chk("R8 slave r_busy_n follows input", {7'b0, r_busy_n}, 8'd1);
    tick();
    l_busy_in_n = 1'b1;
    idle();
    drive(1'b1, 1'b0, 14'h061, 8'h0, 1'b1, 1'b0, 14'h061, 8'h0);
    chk("R8 slave no arbitration r", {7'b0, r_busy_n}, 8'd1);
    tick();
    chk("R9 blocked left write dropped", l_rdata, 8'h0F);
    chk("R7 slave shared read", r_rdata, 8'h0F);
    idle();
    r_busy_in_n = 1'b0;
    drive(1'b0, 1'b0, 14'h0, 8'h0, 1'b1, 1'b1, 14'h062, 8'hCC);
    tick();
    r_busy_in_n = 1'b1;
    drive(1'b1, 1'b0, 14'h062, 8'h0, 1'b0, 1'b0, 14'h0, 8'h0);
    tick();
    chk("R9 right write blocked, prior write kept", l_rdata, 8'hBB);

    idle();
    summary();
    $finish;
  end
endmodule